// File: doc/BRIEF.md
# Bit Counting Unit

A purely combinational counting stage for a 64-bit processor datapath. From a single operand it produces one of three counts: the number of zero bits above the highest set bit (leading zeros), the number of zero bits below the lowest set bit (trailing zeros), or the number of set bits (population count). A select input picks the count. The result is returned as a full datapath word, with the count in the low bits and zeros above.

A word-mode flag restricts every count to the low 32 bits of the operand. This mode does not use a narrower counter. The operand is shaped before it enters the shared 64-bit counters, and the leading-zero result is corrected afterwards. Word mode exists only when the datapath is wider than the word. The surrounding pipeline handles decode, register access and timing.

Top module: `bitcount_unit`

## Requirements
- R1: With word mode off and select 00, the result is the number of zero bits above the highest set bit of the 64-bit operand, and 64 when the operand is zero.
- R2: With word mode off and select 01, the result is the number of zero bits below the lowest set bit of the 64-bit operand, and 64 when the operand is zero.
- R3: With word mode off and select 10, the result is the number of one bits in the 64-bit operand.
- R4: With word mode on and select 00, the result is the leading-zero count of operand bits 31:0 taken as a 32-bit value. It is 32 when those bits are zero, and bits 63:32 have no effect.
- R5: With word mode on and select 01, the result is the trailing-zero count of operand bits 31:0. It is 32 when those bits are zero, and bits 63:32 have no effect.
- R6: With word mode on and select 10, the result is the number of one bits in operand bits 31:0, and bits 63:32 have no effect.
- R7: Select 11 is reserved and gives a result of zero in either mode.
- R8: Result bits 63:7 are always zero. The count is carried in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | Operand to be counted |
| op_sel | input | 2 | Count select: 00 leading zeros, 01 trailing zeros, 10 ones, 11 reserved |
| word_mode | input | 1 | Restrict the count to operand bits 31:0 |
| result | output | 64 | Zero-extended count |

## Verification
The leading-zero and trailing-zero counts both depend on where the set bits of one operand sit. For a single set bit, the two counts must add up to the counted width minus one. The bench walks a single set bit through every position and applies both counts in both modes. Each result is compared with an independent bench function, and the pairing rule is checked on top of that. Operands with only the upper half set are applied in word mode, where both counts must read 32 and the population count must read zero.

// File: rtl/bitcount_pkg.sv
// Shared definitions for the bit counting unit.
// Assumes a two-bit count select.
package bitcount_pkg;
    typedef enum logic [1:0] {
        CNT_LEAD  = 2'b00,
        CNT_TRAIL = 2'b01,
        CNT_ONES  = 2'b10,
        CNT_NONE  = 2'b11
    } cnt_sel_e;
endpackage

// File: rtl/bc_lead_zero.sv
// Leading-zero counter over a W-bit vector. Returns W for an all-zero vector.
// Assumes CW is wide enough to hold W.
module bc_lead_zero #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Scan upwards so that the highest set bit is the last one to write the count.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < int'(W); i++) begin
            if (vec[i]) cnt = CW'(int'(W) - 1 - i);
        end
    end
endmodule

// File: rtl/bc_trail_zero.sv
// Trailing-zero counter built by reversing the vector into a leading-zero counter.
// Returns W for an all-zero vector.
module bc_trail_zero #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [W-1:0] flipped;

    // Mirror the bit order, one wire per position.
    for (genvar g = 0; g < int'(W); g++) begin : g_flip
        assign flipped[g] = vec[W-1-g];
    end

    bc_lead_zero #(.W(W), .CW(CW)) u_lz (
        .vec (flipped),
        .cnt (cnt)
    );
endmodule

// File: rtl/bc_ones.sv
// Population counter over a W-bit vector.
// Assumes CW is wide enough to hold W.
module bc_ones #(
    parameter int unsigned W  = 64,
    parameter int unsigned CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Sum every bit into the count.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < int'(W); i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/bitcount_unit.sv
// Bit counting unit: leading zeros, trailing zeros or ones of one operand.
// Word mode shapes the operand for the shared full-width counters:
// the high half is zeroed for the leading and ones counts and filled with
// ones for the trailing count. The leading count is then reduced by WORD.
// Word mode exists only when XLEN > WORD. The block is purely combinational.
module bitcount_unit #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WORD = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [1:0]      op_sel,
    input  logic            word_mode,
    output logic [XLEN-1:0] result
);
    import bitcount_pkg::*;

    localparam int unsigned CW = $clog2(XLEN + 1);

    logic [XLEN-1:0] zext_in;
    logic [XLEN-1:0] fill_in;
    logic [CW-1:0]   lead_adj;
    logic [CW-1:0]   lead_raw;
    logic [CW-1:0]   trail_cnt;
    logic [CW-1:0]   ones_cnt;
    logic [CW-1:0]   pick;

    if (XLEN > WORD) begin : g_word
        localparam int unsigned HI = XLEN - WORD;
        // Shape the operand for word mode and set the leading-count correction.
        always_comb begin
            zext_in  = word_mode ? {{HI{1'b0}}, op_a[WORD-1:0]} : op_a;
            fill_in  = word_mode ? {{HI{1'b1}}, op_a[WORD-1:0]} : op_a;
            lead_adj = word_mode ? CW'(WORD) : '0;
        end
    end else begin : g_full
        // No word mode at this width: pass the operand straight through.
        always_comb begin
            zext_in  = op_a;
            fill_in  = op_a;
            lead_adj = '0;
        end
    end

    bc_lead_zero  #(.W(XLEN), .CW(CW)) u_lead  (.vec(zext_in), .cnt(lead_raw));
    bc_trail_zero #(.W(XLEN), .CW(CW)) u_trail (.vec(fill_in), .cnt(trail_cnt));
    bc_ones       #(.W(XLEN), .CW(CW)) u_ones  (.vec(zext_in), .cnt(ones_cnt));

    // Choose the count named by the select. The reserved code gives zero.
    always_comb begin
        unique case (cnt_sel_e'(op_sel))
            CNT_LEAD:  pick = lead_raw - lead_adj;
            CNT_TRAIL: pick = trail_cnt;
            CNT_ONES:  pick = ones_cnt;
            default:   pick = '0;
        endcase
    end

    // Zero-extend the count to the datapath width.
    assign result = {{(XLEN-CW){1'b0}}, pick};
endmodule

// File: rtl/bitcount_unit_check.sv
// Checker for the bit counting unit, attached to it by bind.
// It uses immediate assertions because the unit has no clock.
module bitcount_unit_check #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WORD = 32
) (
    input logic [XLEN-1:0] op_a,
    input logic [1:0]      op_sel,
    input logic            word_mode,
    input logic [XLEN-1:0] result
);
    localparam int unsigned CW = $clog2(XLEN + 1);

    // Compare the output with properties the counts must satisfy.
    always_comb begin
        p_upper_zero_r8: assert (result[XLEN-1:CW] == '0)
            else $error("upper result bits set");
        p_reserved_zero_r7: assert (!(op_sel == 2'b11) || result == '0)
            else $error("reserved select gave nonzero");
        p_ones_full_r3: assert (!(op_sel == 2'b10 && !word_mode)
                                 || result == XLEN'($countones(op_a)))
            else $error("ones count wrong");
        p_ones_word_r6: assert (!(op_sel == 2'b10 && word_mode)
                                 || result == XLEN'($countones(op_a[WORD-1:0])))
            else $error("word ones count wrong");
        p_trail_zero_r2: assert (!(op_sel == 2'b01 && !word_mode && op_a == '0)
                                  || result == XLEN'(XLEN))
            else $error("trailing count of zero operand");
        p_lead_bound_r4: assert (!(op_sel == 2'b00 && word_mode)
                                  || result <= XLEN'(WORD))
            else $error("word leading count out of range");
        p_trail_bound_r5: assert (!(op_sel == 2'b01 && word_mode)
                                   || result <= XLEN'(WORD))
            else $error("word trailing count out of range");
        p_lead_zero_r1: assert (!(op_sel == 2'b00 && !word_mode && op_a == '0)
                                 || result == XLEN'(XLEN))
            else $error("leading count of zero operand");
    end
endmodule

bind bitcount_unit bitcount_unit_check #(.XLEN(XLEN), .WORD(WORD)) u_check (
    .op_a      (op_a),
    .op_sel    (op_sel),
    .word_mode (word_mode),
    .result    (result)
);

// File: tb/tb_bitcount_unit.sv
// Self-checking bench for the bit counting unit. It applies directed and
// random operands and compares the output with bench reference functions.
module tb_bitcount_unit;
    localparam int PERIOD = 10;
    localparam int WDOG   = 150000;

    logic        clk = 1'b0;
    logic [63:0] op_a = '0;
    logic [1:0]  op_sel = '0;
    logic        word_mode = 1'b0;
    logic [63:0] result;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bitcount_unit dut (
        .op_a      (op_a),
        .op_sel    (op_sel),
        .word_mode (word_mode),
        .result    (result)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int ref_lead(input logic [63:0] v, input int w);
        for (int i = w - 1; i >= 0; i--) if (v[i]) return w - 1 - i;
        return w;
    endfunction

    function automatic int ref_trail(input logic [63:0] v, input int w);
        for (int i = 0; i < w; i++) if (v[i]) return i;
        return w;
    endfunction

    function automatic int ref_ones(input logic [63:0] v, input int w);
        int n = 0;
        for (int i = 0; i < w; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic [63:0] expect_of(input logic [63:0] v, input logic [1:0] s,
                                              input logic wm);
        int w = wm ? 32 : 64;
        case (s)
            2'b00:   return 64'(ref_lead(v, w));
            2'b01:   return 64'(ref_trail(v, w));
            2'b10:   return 64'(ref_ones(v, w));
            default: return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] s, input logic wm);
        case (s)
            2'b00:   return wm ? "R4" : "R1";
            2'b01:   return wm ? "R5" : "R2";
            2'b10:   return wm ? "R6" : "R3";
            default: return "R7";
        endcase
    endfunction

    // Apply one case and compare at the falling edge.
    task automatic run_one(input logic [63:0] v, input logic [1:0] s, input logic wm,
                           output logic [63:0] got);
        logic [63:0] exp;
        @(posedge clk);
        op_a = v; op_sel = s; word_mode = wm;
        @(negedge clk);
        got = result;
        exp = expect_of(v, s, wm);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%h sel=%b word=%b got=%h exp=%h",
                     tag_of(s, wm), v, s, wm, got, exp);
        end
        total++;
        if (got[63:7] !== '0) begin
            bad++;
            $display("FAIL R8 op=%h got=%h exp upper bits zero", v, got);
        end
    endtask

    task automatic run_all(input logic [63:0] v);
        logic [63:0] g;
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++) run_one(v, 2'(s), 1'(m), g);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(PERIOD * WDOG);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired got=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] lz, tz;
        void'($urandom(32'd4242));
        // R1: idle inputs (zero operand, select 00) give 64.
        @(negedge clk);
        total++;
        if (result !== 64'd64) begin
            bad++;
            $display("FAIL R1 idle got=%h exp=%h", result, 64'd64);
        end
        run_all(64'h0);
        run_all('1);
        run_all(64'hAAAA_AAAA_AAAA_AAAA);
        run_all(64'h5555_5555_5555_5555);
        // R4/R5/R6: only the upper half set, word mode must ignore it.
        run_all(64'hFFFF_FFFF_0000_0000);
        run_all(64'h8000_0000_0000_0000);
        run_all(64'h0000_0001_0000_0000);
        // Single set bit walked across every position: lead + trail = width - 1.
        for (int b = 0; b < 64; b++) begin
            logic [63:0] v = 64'd1 << b;
            run_all(v);
            for (int m = 0; m < 2; m++) begin
                if (m == 1 && b >= 32) continue;
                run_one(v, 2'b00, 1'(m), lz);
                run_one(v, 2'b01, 1'(m), tz);
                total++;
                if (lz + tz !== 64'(m ? 31 : 63)) begin
                    bad++;
                    $display("FAIL %s bit=%0d lead+trail got=%0d exp=%0d",
                             m ? "R4" : "R1", b, lz + tz, m ? 31 : 63);
                end
            end
        end
        // Random operands, thinned and shifted to spread the counts.
        for (int k = 0; k < 1500; k++) begin
            logic [63:0] v = {$urandom, $urandom};
            case ($urandom % 4)
                0: v = v & {$urandom, $urandom} & {$urandom, $urandom};
                1: v = v >> ($urandom % 64);
                2: v = v << ($urandom % 64);
                default: ;
            endcase
            run_all(v);
        end
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule